// File: doc/BRIEF.md
# Redundant Dual-Rail Reset Synchronizer

This block turns two independent pairs of active-low reset inputs into clean internal resets. One pair serves the main domain and the other the debug/monitor domain. Each member of a pair is a separate rail with its own synchronizer and its own synchronized output. A domain enters reset only when both of its rails are asserted together. Entry into reset is asynchronous and hits both rails of the pair at the same instant. Exit from reset is synchronous to the destination clock. A single rail that is stuck asserted therefore cannot force the domain into reset. A single rail that is stuck deasserted prevents the domain from being reset at all.

Each rail of the main pair also takes an active-low memory self-test reset. It is ANDed with that rail's functional input before the rail enters the synchronizer.

Each domain has a monitor with two sticky flags, both cleared by a dedicated clear input:

- **Short-pulse flag:** set when the combined reset was held for fewer than 16 clock edges.
- **Disagreement flag:** set when the two synchronized rails differ for more than 4 consecutive clock edges.

Both flags survive the domain reset, so they can be read once the domain is running again.

Top module: `dual_rail_rst_sync`

## Requirements
- R1: When both rails of a pair are low, both synchronized rail outputs and the combined domain reset of that pair go low at once, with no clock edge needed.
- R2: A single rail held low while its partner is high changes none of that domain's outputs, and a rail that has released does not reassert on its own.
- R3: Once a pair is no longer both-low, a rail output goes high at the second rising clock edge after its own input is high (SYNC_STAGES = 2).
- R4: The combined domain reset is high only when both synchronized rails of the pair have released.
- R5: Activity on one domain's pair never changes the other domain's outputs or flags.
- R6: Each main rail's effective input is the AND of its functional input and its self-test reset input. The debug pair has no self-test input.
- R7: The monitor counts the rising edges at which the combined reset is low, including the two release edges of the synchronizer. At the first edge at which the reset is seen high, it sets the sticky short flag if that count is below MIN_HOLD = 16.
- R8: The sticky disagreement flag is set on the fifth consecutive rising edge at which the two synchronized rails of a pair differ. Four or fewer consecutive edges leave it clear.
- R9: A high flag_clr at a rising edge clears both flags of both domains. Otherwise, a set flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination clock |
| main_a_n | input | 1 | Main domain primary reset, active low |
| main_b_n | input | 1 | Main domain duplicate reset, active low |
| bist_a_n | input | 1 | Self-test reset for main primary rail, active low |
| bist_b_n | input | 1 | Self-test reset for main duplicate rail, active low |
| dbg_a_n | input | 1 | Debug domain primary reset, active low |
| dbg_b_n | input | 1 | Debug domain duplicate reset, active low |
| flag_clr | input | 1 | Synchronous clear of all sticky flags |
| main_a_sync_n | output | 1 | Synchronized main primary rail |
| main_b_sync_n | output | 1 | Synchronized main duplicate rail |
| dbg_a_sync_n | output | 1 | Synchronized debug primary rail |
| dbg_b_sync_n | output | 1 | Synchronized debug duplicate rail |
| main_rst_n | output | 1 | Combined main domain reset, active low |
| dbg_rst_n | output | 1 | Combined debug domain reset, active low |
| main_short | output | 1 | Sticky short-reset flag, main domain |
| dbg_short | output | 1 | Sticky short-reset flag, debug domain |
| main_split | output | 1 | Sticky rail disagreement flag, main domain |
| dbg_split | output | 1 | Sticky rail disagreement flag, debug domain |

## Verification
The assertions check four things on every clock:

- a released rail stays released until its pair is both-low again;
- a both-low pair holds the domain in reset;
- a flag rises only right after a release or a run of rail mismatch;
- the hold counter never passes its limit.

Some behaviours only the bench scenarios can show. These are the exact release latency, the threshold of 16 hold edges, the threshold between four and five mismatch edges, the self-test gating and the isolation between domains. The bench checks them with sweeps over hold lengths and rail skews, whose expected flags are computed arithmetically.

// File: rtl/rst_pkg.sv
package rst_pkg;
    localparam int NUM_DOM  = 2;
    localparam int DOM_MAIN = 0;
    localparam int DOM_DBG  = 1;
    localparam int NUM_RAIL = 2;
endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pair_arst_n,
    input  logic rail_n,
    output logic rel_n
);
    logic [STAGES-1:0] chain_d, chain_q;

    // A released rail feeds itself, so it can only be pulled low by the pair clear.
    always_comb begin
        chain_d = {chain_q[STAGES-2:0], rail_n | chain_q[STAGES-1]};
    end

    always_ff @(posedge clk or negedge pair_arst_n) begin
        if (!pair_arst_n) chain_q <= '0;
        else              chain_q <= chain_d;
    end

    assign rel_n = chain_q[STAGES-1];

    // R2
    stays_released_chk: assert property (@(posedge clk) disable iff (!pair_arst_n)
        rel_n |=> rel_n);
endmodule

// File: rtl/hold_monitor.sv
module hold_monitor #(
    parameter int MIN_HOLD    = 16,
    parameter int SPLIT_LIMIT = 4
) (
    input  logic clk,
    input  logic flag_clr,
    input  logic dom_rst_n,
    input  logic rel_a_n,
    input  logic rel_b_n,
    output logic short_flag,
    output logic split_flag
);
    localparam int HW = $clog2(MIN_HOLD + 1);
    localparam int SW = $clog2(SPLIT_LIMIT + 1);
    localparam logic [HW-1:0] HOLD_TOP = HW'(MIN_HOLD);
    localparam logic [SW-1:0] DIFF_TOP = SW'(SPLIT_LIMIT);

    typedef struct packed {
        logic [HW-1:0] hold;
        logic [SW-1:0] diff;
        logic          short_f;
        logic          split_f;
    } mon_t;

    mon_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!dom_rst_n) begin
            if (st_q.hold != HOLD_TOP) st_d.hold = st_q.hold + 1'b1;
        end else begin
            st_d.hold = '0;
            if (st_q.hold != '0 && st_q.hold < HOLD_TOP) st_d.short_f = 1'b1;
        end
        if (rel_a_n ^ rel_b_n) begin
            if (st_q.diff == DIFF_TOP) st_d.split_f = 1'b1;
            else                       st_d.diff    = st_q.diff + 1'b1;
        end else begin
            st_d.diff = '0;
        end
        if (flag_clr) begin
            st_d.short_f = 1'b0;
            st_d.split_f = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign short_flag = st_q.short_f;
    assign split_flag = st_q.split_f;

    // R7
    short_after_release_chk: assert property (@(posedge clk) disable iff (flag_clr)
        $rose(short_flag) |-> ($past(dom_rst_n) && !$past(dom_rst_n, 2)));

    // R8
    split_after_mismatch_chk: assert property (@(posedge clk) disable iff (flag_clr)
        $rose(split_flag) |-> $past(rel_a_n != rel_b_n));

    // R7
    hold_bound_chk: assert property (@(posedge clk) disable iff (flag_clr)
        st_q.hold <= HOLD_TOP);
endmodule

// File: rtl/pair_gate.sv
module pair_gate #(
    parameter int STAGES      = 2,
    parameter int MIN_HOLD    = 16,
    parameter int SPLIT_LIMIT = 4
) (
    input  logic       clk,
    input  logic       flag_clr,
    input  logic [1:0] rail_in_n,
    output logic [1:0] rail_rel_n,
    output logic       dom_rst_n,
    output logic       short_flag,
    output logic       split_flag
);
    logic pair_arst_n;

    // Only both rails low clears the synchronizers.
    assign pair_arst_n = rail_in_n[0] | rail_in_n[1];

    for (genvar r = 0; r < rst_pkg::NUM_RAIL; r++) begin : g_rail
        rail_sync #(.STAGES(STAGES)) u_rail (
            .clk        (clk),
            .pair_arst_n(pair_arst_n),
            .rail_n     (rail_in_n[r]),
            .rel_n      (rail_rel_n[r])
        );
    end

    assign dom_rst_n = rail_rel_n[0] & rail_rel_n[1];

    hold_monitor #(.MIN_HOLD(MIN_HOLD), .SPLIT_LIMIT(SPLIT_LIMIT)) u_mon (
        .clk       (clk),
        .flag_clr  (flag_clr),
        .dom_rst_n (dom_rst_n),
        .rel_a_n   (rail_rel_n[0]),
        .rel_b_n   (rail_rel_n[1]),
        .short_flag(short_flag),
        .split_flag(split_flag)
    );

    // R1
    both_low_holds_chk: assert property (@(posedge clk) disable iff (pair_arst_n)
        !dom_rst_n);
endmodule

// File: rtl/dual_rail_rst_sync.sv
module dual_rail_rst_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HOLD    = 16,
    parameter int SPLIT_LIMIT = 4
) (
    input  logic clk,
    input  logic main_a_n,
    input  logic main_b_n,
    input  logic bist_a_n,
    input  logic bist_b_n,
    input  logic dbg_a_n,
    input  logic dbg_b_n,
    input  logic flag_clr,
    output logic main_a_sync_n,
    output logic main_b_sync_n,
    output logic dbg_a_sync_n,
    output logic dbg_b_sync_n,
    output logic main_rst_n,
    output logic dbg_rst_n,
    output logic main_short,
    output logic dbg_short,
    output logic main_split,
    output logic dbg_split
);
    import rst_pkg::*;

    logic [1:0] dom_in_n  [NUM_DOM];
    logic [1:0] dom_rel_n [NUM_DOM];
    logic       dom_rst   [NUM_DOM];
    logic       dom_short [NUM_DOM];
    logic       dom_split [NUM_DOM];

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        if (d == DOM_MAIN) begin : g_bist
            assign dom_in_n[d] = {main_b_n & bist_b_n, main_a_n & bist_a_n};
        end else begin : g_plain
            assign dom_in_n[d] = {dbg_b_n, dbg_a_n};
        end

        pair_gate #(
            .STAGES     (SYNC_STAGES),
            .MIN_HOLD   (MIN_HOLD),
            .SPLIT_LIMIT(SPLIT_LIMIT)
        ) u_pair (
            .clk       (clk),
            .flag_clr  (flag_clr),
            .rail_in_n (dom_in_n[d]),
            .rail_rel_n(dom_rel_n[d]),
            .dom_rst_n (dom_rst[d]),
            .short_flag(dom_short[d]),
            .split_flag(dom_split[d])
        );
    end

    assign main_a_sync_n = dom_rel_n[DOM_MAIN][0];
    assign main_b_sync_n = dom_rel_n[DOM_MAIN][1];
    assign dbg_a_sync_n  = dom_rel_n[DOM_DBG][0];
    assign dbg_b_sync_n  = dom_rel_n[DOM_DBG][1];
    assign main_rst_n    = dom_rst[DOM_MAIN];
    assign dbg_rst_n     = dom_rst[DOM_DBG];
    assign main_short    = dom_short[DOM_MAIN];
    assign dbg_short     = dom_short[DOM_DBG];
    assign main_split    = dom_split[DOM_MAIN];
    assign dbg_split     = dom_split[DOM_DBG];
endmodule

// File: tb/test_dual_rail_rst_sync.sv
`timescale 1ns/1ps
module test_dual_rail_rst_sync;
    logic clk = 1'b0;
    logic main_a_n, main_b_n, bist_a_n, bist_b_n, dbg_a_n, dbg_b_n, flag_clr;
    logic main_a_sync_n, main_b_sync_n, dbg_a_sync_n, dbg_b_sync_n;
    logic main_rst_n, dbg_rst_n, main_short, dbg_short, main_split, dbg_split;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_rail_rst_sync i_dual_rail_rst_sync (
        .clk(clk), .main_a_n(main_a_n), .main_b_n(main_b_n),
        .bist_a_n(bist_a_n), .bist_b_n(bist_b_n),
        .dbg_a_n(dbg_a_n), .dbg_b_n(dbg_b_n), .flag_clr(flag_clr),
        .main_a_sync_n(main_a_sync_n), .main_b_sync_n(main_b_sync_n),
        .dbg_a_sync_n(dbg_a_sync_n), .dbg_b_sync_n(dbg_b_sync_n),
        .main_rst_n(main_rst_n), .dbg_rst_n(dbg_rst_n),
        .main_short(main_short), .dbg_short(dbg_short),
        .main_split(main_split), .dbg_split(dbg_split)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        check(act === exp, req, int'(act), int'(exp));
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        main_a_n = 0; main_b_n = 0; dbg_a_n = 0; dbg_b_n = 0;
        bist_a_n = 1; bist_b_n = 1; flag_clr = 1;
        tick(20);
        // R1 reset state during cold reset
        chk("R1", main_a_sync_n, 0); chk("R1", main_b_sync_n, 0);
        chk("R1", dbg_a_sync_n, 0);  chk("R1", dbg_b_sync_n, 0);
        chk("R1", main_rst_n, 0);    chk("R1", dbg_rst_n, 0);
        chk("R9", main_short, 0);    chk("R9", main_split, 0);
        main_a_n = 1; main_b_n = 1; dbg_a_n = 1; dbg_b_n = 1; flag_clr = 0;
        tick(1);
        // R3 still in reset after one edge
        chk("R3", main_rst_n, 0); chk("R3", dbg_rst_n, 0);
        tick(1);
        chk("R3", main_rst_n, 1); chk("R3", dbg_rst_n, 1);
        chk("R3", main_a_sync_n, 1); chk("R3", dbg_b_sync_n, 1);
        tick(2);
        chk("R7", main_short, 0); chk("R7", dbg_short, 0);

        // R2 single rail low has no effect
        main_a_n = 0; #1;
        chk("R2", main_rst_n, 1); chk("R2", main_a_sync_n, 1);
        tick(6);
        chk("R2", main_rst_n, 1); chk("R2", main_a_sync_n, 1); chk("R2", main_b_sync_n, 1);
        // R1 partner asserts: immediate, no edge
        main_b_n = 0; #1;
        chk("R1", main_rst_n, 0); chk("R1", main_a_sync_n, 0); chk("R1", main_b_sync_n, 0);
        chk("R5", dbg_rst_n, 1);
        tick(20);
        main_a_n = 1; main_b_n = 1;
        tick(2);
        chk("R3", main_rst_n, 1);
        chk("R7", main_short, 0);
        // R2 stuck deasserted partner: pulsing one rail never resets
        for (int i = 0; i < 4; i++) begin
            main_b_n = 0; tick(3); main_b_n = 1; tick(1);
            chk("R2", main_rst_n, 1);
        end

        // R7 hold-length sweep: low edges counted = h + 2
        for (int h = 1; h <= 20; h++) begin
            main_a_n = 0; main_b_n = 0;
            tick(h);
            main_a_n = 1; main_b_n = 1;
            tick(4);
            chk("R7", main_short, ((h + 2) < 16));
            chk("R5", dbg_short, 0);
            tick(10);
            chk("R9", main_short, ((h + 2) < 16));
            clear_flags();
            chk("R9", main_short, 0);
        end

        // R8 skew sweep on debug pair: mismatch edges = k
        for (int k = 0; k <= 8; k++) begin
            dbg_a_n = 0; dbg_b_n = 0;
            tick(20);
            dbg_b_n = 1;
            tick(k);
            if (k >= 2) begin
                // R4 one rail released, domain still held
                chk("R4", dbg_b_sync_n, 1); chk("R4", dbg_a_sync_n, 0);
                chk("R4", dbg_rst_n, 0);
            end
            dbg_a_n = 1;
            tick(6);
            chk("R4", dbg_rst_n, 1);
            chk("R8", dbg_split, (k > 4));
            chk("R5", main_split, 0);
            clear_flags();
            chk("R9", dbg_split, 0);
        end

        // R6 self-test gating
        bist_a_n = 0; #1;
        chk("R6", main_rst_n, 1);
        tick(3);
        chk("R6", main_rst_n, 1);
        main_b_n = 0; #1;
        chk("R6", main_rst_n, 0);
        tick(20);
        bist_a_n = 1; main_b_n = 1;
        tick(2);
        chk("R6", main_rst_n, 1);
        bist_a_n = 0; bist_b_n = 0; #1;
        chk("R6", main_rst_n, 0);
        chk("R5", dbg_rst_n, 1);
        tick(20);
        bist_a_n = 1; bist_b_n = 1;
        tick(2);
        chk("R6", main_rst_n, 1);
        chk("R7", main_short, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule